// File: doc/BRIEF.md
# Five-State Buck-Boost Switch Sequencer

This block drives the gate enables of a non-inverting buck-boost converter whose output follows a moving reference voltage. Two comparator bits come in: one says the output sits below the reference, the other comes from a single current comparator. The block itself chooses whether that comparator looks for an empty inductor or for the current limit, by turning on one of two selector switches. Energy flows both ways. The inductor is charged from the input and dumped into the load. Leftover energy goes back to the input. When the output must fall, the load capacitor is drained into the inductor and that energy is returned to the input.

The machine has five major states: charge, deliver, return, drain and discharge. On every change of state all switches open first. They stay open for a programmable dead time, and only then does the next switch set close. After the new set closes, the comparators are ignored for a programmable settling time, which hides the comparators' response delay. Both comparator bits pass through two-flop synchronizers. Dead time and settling time are counted in clock cycles, and each has a minimum of one.

Top module: `bb_switch_ctrl`

## Requirements
- R1: While rst_ni is low, gate_o equals 0x040 at once, with no clock edge needed. This is the all-open pattern: bit 6 is the active-low drive of the P side of the pass gate.
- R2: After reset is released, gate_o stays 0x040 through the first DEAD_CYC-1 rising edges. The charge pattern appears after the DEAD_CYC-th rising edge.
- R3: The gate_o bit map is: 0 input high-side, 1 output low-side, 2 output sense, 3 input low-side, 4 input sense, 5 pass-gate N, 6 pass-gate P (active low), 7 return switch, 8 limit selector, 9 zero selector. The state patterns are: charge 0x159, deliver 0x226, return 0x2C6, drain 0x126, discharge 0x259.
- R4: In charge, the machine holds while cur_cmp_i is 0. When cur_cmp_i is 1 (limit reached), it moves to deliver.
- R5: In deliver, below_ref_i = 0 (reference reached) moves the machine to return, and this takes priority over the current bit. below_ref_i = 1 with cur_cmp_i = 1 (inductor empty) moves it to charge.
- R6: In return, cur_cmp_i = 1 (inductor empty) moves the machine to charge if below_ref_i = 1, and to drain otherwise.
- R7: In drain, below_ref_i = 1 or cur_cmp_i = 1 (limit reached) moves the machine to discharge.
- R8: In discharge, cur_cmp_i = 1 (inductor empty) moves the machine to charge if below_ref_i = 1, and to drain otherwise.
- R9: Every change of switch set passes through exactly DEAD_CYC cycles of 0x040. One closed set never changes straight into another.
- R10: For STAB_CYC of 2 or more, a set whose exit condition is already present when it closes stays on for exactly STAB_CYC+1 cycles. Comparator values have no effect during settling.
- R11: Once the settling time is over, a comparator change that satisfies an exit condition opens the switches on the third rising edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| below_ref_i | input | 1 | 1 when the output voltage is below the reference |
| cur_cmp_i | input | 1 | Shared current comparator: 1 when the selected threshold (limit or zero) is reached |
| gate_o | output | 10 | Switch gate enables, bit map as in R3 |

## Verification
A wrong internal state shows up directly as a wrong gate pattern. It appears on the cycle after the faulty transition edge, because gate_o is decoded from the state registers without added delay. A miscounted dead time or settling time changes the number of cycles an off or on pattern lasts, so the bench counts every such run at the ports. A wrong branch choice shows as an unexpected pattern after the dead gap. An overlap of two switch sets shows as a pattern change that does not pass through 0x040.

// File: rtl/bb_ctrl_pkg.sv
package bb_ctrl_pkg;
  typedef enum logic [2:0] {ST_CHGL, ST_LTOC, ST_LTOV, ST_CTOL, ST_DISL} state_e;
  typedef enum logic [1:0] {PH_DEAD, PH_SETTLE, PH_ARMED} phase_e;

  localparam int NSW        = 10;
  localparam int SW_SRC_TOP = 0;
  localparam int SW_OUT_GND = 1;
  localparam int SW_OUT_SNS = 2;
  localparam int SW_IN_GND  = 3;
  localparam int SW_IN_SNS  = 4;
  localparam int SW_TG_N    = 5;
  localparam int SW_TG_PN   = 6;
  localparam int SW_SRC_RET = 7;
  localparam int SW_SEL_LIM = 8;
  localparam int SW_SEL_ZER = 9;

  localparam logic [NSW-1:0] GATE_OFF = NSW'(1) << SW_TG_PN;

  function automatic logic [NSW-1:0] gate_map(state_e s);
    logic [NSW-1:0] g;
    g = '0;
    case (s)
      ST_CHGL, ST_DISL: begin
        g[SW_SRC_TOP] = 1'b1;
        g[SW_IN_GND]  = 1'b1;
        g[SW_IN_SNS]  = 1'b1;
      end
      default: begin
        g[SW_OUT_GND] = 1'b1;
        g[SW_OUT_SNS] = 1'b1;
      end
    endcase
    case (s)
      ST_LTOC, ST_CTOL: g[SW_TG_N] = 1'b1;
      ST_LTOV:          g[SW_SRC_RET] = 1'b1;
      default:          ;
    endcase
    // limit sense only while current builds toward the limit
    if (s == ST_CHGL || s == ST_CTOL) g[SW_SEL_LIM] = 1'b1;
    else                              g[SW_SEL_ZER] = 1'b1;
    g[SW_TG_PN] = ~g[SW_TG_N];
    return g;
  endfunction
endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/bb_delay_timer.sv
module bb_delay_timer #(
  parameter int          CW      = 2,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_VAL;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/bb_next_state.sv
module bb_next_state
  import bb_ctrl_pkg::*;
(
  input  state_e state_i,
  input  logic   below_i,
  input  logic   cur_i,
  output logic   go_o,
  output state_e next_o
);
  always_comb begin
    go_o   = 1'b0;
    next_o = state_i;
    case (state_i)
      ST_CHGL: if (cur_i) begin go_o = 1'b1; next_o = ST_LTOC; end
      ST_LTOC: begin
        if (!below_i)   begin go_o = 1'b1; next_o = ST_LTOV; end
        else if (cur_i) begin go_o = 1'b1; next_o = ST_CHGL; end
      end
      ST_LTOV, ST_DISL: if (cur_i) begin
        go_o   = 1'b1;
        next_o = below_i ? ST_CHGL : ST_CTOL;
      end
      ST_CTOL: if (below_i || cur_i) begin go_o = 1'b1; next_o = ST_DISL; end
      default: begin go_o = 1'b1; next_o = ST_CHGL; end
    endcase
  end
endmodule

// File: rtl/bb_switch_ctrl.sv
module bb_switch_ctrl
  import bb_ctrl_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int STAB_CYC = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           below_ref_i,
  input  logic           cur_cmp_i,
  output logic [NSW-1:0] gate_o
);
  localparam int MAXC = (DEAD_CYC > STAB_CYC) ? DEAD_CYC : STAB_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] STAB_V = CW'(STAB_CYC - 1);

  logic    blw_s, cur_s, go, done, load;
  logic [CW-1:0] load_val;
  state_e  state_q, state_d, nxt;
  phase_e  phase_q, phase_d;

  bb_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({below_ref_i, cur_cmp_i}),
    .q_o   ({blw_s, cur_s})
  );

  bb_next_state u_nxt (
    .state_i(state_q),
    .below_i(blw_s),
    .cur_i  (cur_s),
    .go_o   (go),
    .next_o (nxt)
  );

  bb_delay_timer #(.CW(CW), .RST_VAL(DEAD_V)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (load_val),
    .done_o(done)
  );

  always_comb begin
    phase_d  = phase_q;
    state_d  = state_q;
    load     = 1'b0;
    load_val = DEAD_V;
    case (phase_q)
      PH_DEAD:   if (done) begin phase_d = PH_SETTLE; load = 1'b1; load_val = STAB_V; end
      PH_SETTLE: if (done) phase_d = PH_ARMED;
      PH_ARMED:  if (go) begin phase_d = PH_DEAD; state_d = nxt; load = 1'b1; end
      default:   begin phase_d = PH_DEAD; load = 1'b1; end
    endcase
  end

  // reset parks in the dead phase with charge as the pending target
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DEAD;
      state_q <= ST_CHGL;
    end else begin
      phase_q <= phase_d;
      state_q <= state_d;
    end
  end

  assign gate_o = (phase_q == PH_DEAD) ? GATE_OFF : gate_map(state_q);

  p_reset_off_r1: assert property (@(posedge clk_i) !rst_ni |-> gate_o == GATE_OFF);

  p_break_before_make_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != GATE_OFF) |=> (gate_o == GATE_OFF) || $stable(gate_o));

  p_settle_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETTLE) |=> (phase_q != PH_DEAD));

  p_chgl_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ARMED && state_q == ST_CHGL && cur_s) |=>
      (phase_q == PH_DEAD && state_q == ST_LTOC));

  p_ltoc_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ARMED && state_q == ST_LTOC && !blw_s) |=>
      (phase_q == PH_DEAD && state_q == ST_LTOV));
endmodule

// File: tb/tb_bb_switch_ctrl.sv
module tb_bb_switch_ctrl;
  localparam int DEAD = 2;
  localparam int STAB = 3;
  localparam logic [9:0] P_OFF  = 10'h040;
  localparam logic [9:0] P_CHGL = 10'h159;
  localparam logic [9:0] P_LTOC = 10'h226;
  localparam logic [9:0] P_LTOV = 10'h2C6;
  localparam logic [9:0] P_CTOL = 10'h126;
  localparam logic [9:0] P_DISL = 10'h259;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       below_ref_i = 1'b0;
  logic       cur_cmp_i = 1'b0;
  logic [9:0] gate_o;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk_i = ~clk_i;

  bb_switch_ctrl #(.DEAD_CYC(DEAD), .STAB_CYC(STAB)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .below_ref_i(below_ref_i),
    .cur_cmp_i  (cur_cmp_i),
    .gate_o     (gate_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // called at a sample where cur_pat has just appeared
  task automatic step(input logic [9:0] cur_pat, input logic b, input logic c,
                      input logic [9:0] nxt_pat, input int exp_on, input string tag);
    int on_n, off_n;
    check(gate_o == cur_pat, {tag, " R3 pattern"}, gate_o, cur_pat);
    below_ref_i = b;
    cur_cmp_i   = c;
    on_n = 0;
    while (gate_o == cur_pat && on_n < 1000) begin on_n++; @(negedge clk_i); end
    check(on_n == exp_on, {tag, " on-time R10 R11"}, on_n, exp_on);
    off_n = 0;
    while (gate_o == P_OFF && off_n < 1000) begin off_n++; @(negedge clk_i); end
    check(off_n == DEAD, {tag, " dead gap R9"}, off_n, DEAD);
    check(gate_o == nxt_pat, {tag, " next state"}, gate_o, nxt_pat);
  endtask

  task automatic t_reset_start();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(gate_o == P_OFF, "R1 async off", gate_o, P_OFF);
    @(negedge clk_i);
    @(negedge clk_i);
    check(gate_o == P_OFF, "R1 held off", gate_o, P_OFF);
    rst_ni = 1'b1;
    for (int i = 1; i <= DEAD; i++) begin
      @(negedge clk_i);
      if (i < DEAD) check(gate_o == P_OFF, "R2 off after release", gate_o, P_OFF);
      else          check(gate_o == P_CHGL, "R2 charge after dead", gate_o, P_CHGL);
    end
  endtask

  task automatic t_charge_hold();
    below_ref_i = 1'b1;
    cur_cmp_i   = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      check(gate_o == P_CHGL, "R4 charge holds", gate_o, P_CHGL);
    end
    step(P_CHGL, 1'b1, 1'b1, P_LTOC, 3, "R11 R4 sync latency");
  endtask

  task automatic t_branches();
    step(P_LTOC, 1'b0, 1'b1, P_LTOV, STAB + 1, "R5 reference priority");
    step(P_LTOV, 1'b1, 1'b1, P_CHGL, STAB + 1, "R6 return to charge");
    step(P_CHGL, 1'b1, 1'b1, P_LTOC, STAB + 1, "R4 R10 masked charge");
    step(P_LTOC, 1'b1, 1'b1, P_CHGL, STAB + 1, "R5 empty to charge");
    step(P_CHGL, 1'b1, 1'b1, P_LTOC, STAB + 1, "R4 charge again");
    step(P_LTOC, 1'b0, 1'b0, P_LTOV, STAB + 1, "R5 reference reached");
    step(P_LTOV, 1'b0, 1'b1, P_CTOL, STAB + 1, "R6 return to drain");
    step(P_CTOL, 1'b0, 1'b1, P_DISL, STAB + 1, "R7 limit exit");
    step(P_DISL, 1'b0, 1'b1, P_CTOL, STAB + 1, "R8 back to drain");
    step(P_CTOL, 1'b1, 1'b0, P_DISL, STAB + 1, "R7 reference exit");
    step(P_DISL, 1'b1, 1'b1, P_CHGL, STAB + 1, "R8 to charge");
  endtask

  task automatic t_drain_hold();
    step(P_CHGL, 1'b1, 1'b1, P_LTOC, STAB + 1, "R4 path");
    step(P_LTOC, 1'b0, 1'b0, P_LTOV, STAB + 1, "R5 path");
    step(P_LTOV, 1'b0, 1'b1, P_CTOL, STAB + 1, "R6 path");
    below_ref_i = 1'b0;
    cur_cmp_i   = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk_i);
      check(gate_o == P_CTOL, "R7 drain holds", gate_o, P_CTOL);
    end
    step(P_CTOL, 1'b0, 1'b1, P_DISL, 3, "R11 R7 drain latency");
  endtask

  task automatic t_mid_reset();
    cur_cmp_i = 1'b0;
    t_reset_start();
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    t_reset_start();
    t_charge_hold();
    t_branches();
    t_drain_hold();
    t_mid_reset();
    summary();
  end
endmodule